// File: doc/BRIEF.md
# Precharged Key Matrix Scanner

This block scans a 12-column by 7-row key matrix on a fixed interval and reports only the keys whose state differs from the previous scan. Each column is preceded by a precharge phase: all column drives are released and the charge output is held high for one settle period. The column is then driven one-hot for a second settle period, and the synchronized row inputs are captured at the end of that window. After the last column the matrix is released and precharged once more, which leaves it idle.

Once the scan is complete, the new snapshot is compared with the stored one in ascending key order, where the key index is row + 7 × column. Each differing key produces one event carrying the index and a pressed flag. The event output is a valid/ready stream. While valid is high and ready is low, the event is held and the comparison walk stalls. No event is dropped, and the stored state of a key is updated only when its event is accepted. The enable input gates the start of new scans. A scan already in progress runs to completion, so an event once offered is never withdrawn.

Timing comes from counters. The settle length is `SETTLE_NS` and the scan interval is `INTERVAL_US`, both converted to cycles from `CLK_HZ`.

Top module: `kbscan_top`

## Requirements
- R1: After reset the column outputs are all 0, charge is 0, event valid is 0, and both the stored and the new key state are all released, so a key held before the first scan is reported as pressed by that scan.
- R2: At most one column is driven at a time. Column n drives select bit n. Bits 7:0 of the select appear on `col_lo` and bits 11:8 on `col_hi`, so column 8 is `col_hi[0]`.
- R3: Each column is preceded by a charge pulse lasting exactly SETTLE cycles, during which all columns are 0. On the cycle the charge falls, that column's select rises and is held for exactly SETTLE cycles. Columns are visited in order 0 to 11.
- R4: After column 11 ends, all columns are 0 and one further charge pulse of SETTLE cycles follows. A scan therefore has 13 charge pulses, and it ends with the matrix released and charge low.
- R5: Row r of the sampled data is bit r of `rows_in`, where 1 means pressed. A key at row r and column c has index r + 7·c.
- R6: After a scan, one event is emitted for each key whose new state differs from its stored state, in ascending index order. The pressed flag equals the new state. The stored state is then updated, so an unchanged key yields no event on the next scan.
- R7: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid`, `ev_index` and `ev_pressed` stay unchanged and the walk does not advance.
- R8: While enabled, scan starts (rising edge of the first charge pulse) occur INTERVAL cycles apart when the previous scan has finished. The first scan starts INTERVAL cycles after enable rises.
- R9: While `enable` is 0 and the block is idle, no charge pulse, column drive or event occurs.
- R10: Rows are captured only at the end of a column's select window. A key pressed and released entirely between scans produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new scans to start |
| col_lo | output | 8 | Column select bits 7:0, one-hot |
| col_hi | output | NCOL-8 | Column select bits 11:8 |
| charge | output | 1 | Precharge pulse, high only while columns released |
| rows_in | input | NROW | Row sense lines, 1 = pressed |
| ev_valid | output | 1 | Change event available |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_index | output | 7 | Key index row + 7·column |
| ev_pressed | output | 1 | New state of the key, 1 = pressed |

## Verification
A corrupted column counter or settle counter shows at the select and charge pins within one settle window, as a wrong one-hot code, a pulse of the wrong length, or a missing precharge between columns. A stale or wrong stored snapshot shows only after the next walk finishes: it appears as a repeated, missing or inverted event, up to one scan interval later. A walk pointer that skips or stalls wrongly shows as events out of ascending order or as an event that changes while ready is low. The bench watches the pin protocol on every cycle and compares each walk against an independent model of the key state.

// File: rtl/kbscan_pkg.sv
package kbscan_pkg;
  typedef enum logic [2:0] {
    SC_IDLE,
    SC_PRECHG,
    SC_STROBE,
    SC_PARK,
    SC_WALK
  } scan_state_e;
endpackage

// File: rtl/kbscan_tick.sv
module kbscan_tick #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = enable && (cnt == LAST);

  // R9: disabling clears the interval so no expiry is pending
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0) && !tick);
endmodule

// File: rtl/kbscan_sync.sv
module kbscan_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/kbscan_seq.sv
module kbscan_seq
  import kbscan_pkg::*;
#(
  parameter int unsigned NCOL       = 12,
  parameter int unsigned SETTLE_CYC = 20,
  localparam int unsigned COL_W     = $clog2(NCOL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             walk_done,
  output logic [NCOL-1:0]  col_sel,
  output logic             charge,
  output logic             sample_en,
  output logic [COL_W-1:0] sample_col,
  output logic             walk_active
);
  localparam int unsigned CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0]    SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [COL_W-1:0] COL_LAST    = COL_W'(NCOL - 1);

  scan_state_e      state;
  logic [CW-1:0]    cnt;
  logic [COL_W-1:0] col;
  logic             settled;

  assign settled = (cnt == SETTLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SC_IDLE;
      cnt   <= '0;
      col   <= '0;
    end else begin
      case (state)
        SC_IDLE: begin
          if (tick && enable) begin
            state <= SC_PRECHG;
            cnt   <= '0;
            col   <= '0;
          end
        end
        SC_PRECHG: begin
          if (settled) begin
            state <= SC_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SC_STROBE: begin
          if (settled) begin
            cnt <= '0;
            if (col == COL_LAST) begin
              state <= SC_PARK;
            end else begin
              col   <= col + 1'b1;
              state <= SC_PRECHG;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SC_PARK: begin
          if (settled) begin
            cnt   <= '0;
            state <= SC_WALK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SC_WALK: begin
          if (walk_done) state <= SC_IDLE;
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NCOL; g++) begin : g_coldrv
      assign col_sel[g] = (state == SC_STROBE) && (col == COL_W'(g));
    end
  endgenerate

  assign charge      = (state == SC_PRECHG) || (state == SC_PARK);
  assign sample_en   = (state == SC_STROBE) && settled;
  assign sample_col  = col;
  assign walk_active = (state == SC_WALK);

  // R2: never two columns driven
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel));
  // R3: precharge only with all columns released
  p_charge_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    charge |-> (col_sel == '0));
  // R3: timed phases end only when the settle count completes
  p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != SC_IDLE) && (state != SC_WALK) && !settled) |=> (state == $past(state)));
  // R4: the last column is followed by a released, precharged matrix
  p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && (col == COL_LAST)) |=> (charge && (col_sel == '0)));
  // R9: no scan starts while disabled
  p_no_scan_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SC_IDLE) && !enable) |=> (state == SC_IDLE));
endmodule

// File: rtl/kbscan_delta.sv
module kbscan_delta #(
  parameter int unsigned NCOL      = 12,
  parameter int unsigned NROW      = 7,
  localparam int unsigned COL_W    = $clog2(NCOL),
  localparam int unsigned KEYS     = NCOL * NROW,
  localparam int unsigned IDX_W    = $clog2(KEYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [COL_W-1:0] sample_col,
  input  logic [NROW-1:0]  rows,
  input  logic             walk_active,
  input  logic             ev_ready,
  output logic             ev_valid,
  output logic [IDX_W-1:0] ev_index,
  output logic             ev_pressed,
  output logic             walk_done
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(KEYS - 1);

  logic [KEYS-1:0]  snap_new;
  logic [KEYS-1:0]  snap_old;
  logic [IDX_W-1:0] idx;
  logic             differs;
  logic             advance;

  assign differs   = snap_new[idx] ^ snap_old[idx];
  assign ev_valid  = walk_active && differs;
  assign advance   = walk_active && (!differs || ev_ready);
  assign walk_done = advance && (idx == IDX_LAST);
  assign ev_index  = idx;
  assign ev_pressed = snap_new[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_new <= '0;
      snap_old <= '0;
    end else begin
      if (sample_en) begin
        snap_new[int'(sample_col) * NROW +: NROW] <= rows;
      end
      if (advance && differs) begin
        snap_old[idx] <= snap_new[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (!walk_active) begin
      idx <= '0;
    end else if (advance) begin
      idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
    end
  end

  // R7: an offered event is held until accepted
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_index) && $stable(ev_pressed)));
  // R6: an accepted event becomes the stored state of that key
  p_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> (snap_old[$past(ev_index)] == $past(ev_pressed)));
endmodule

// File: rtl/kbscan_top.sv
module kbscan_top #(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned SETTLE_NS   = 20_000,
  parameter int unsigned INTERVAL_US = 50_000,
  parameter int unsigned NCOL        = 12,
  parameter int unsigned NROW        = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned KEYS       = NCOL * NROW,
  localparam int unsigned IDX_W      = $clog2(KEYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  output logic [7:0]       col_lo,
  output logic [NCOL-9:0]  col_hi,
  output logic             charge,
  input  logic [NROW-1:0]  rows_in,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [IDX_W-1:0] ev_index,
  output logic             ev_pressed
);
  localparam int unsigned CYC_PER_US   = CLK_HZ / 1_000_000;
  localparam int unsigned SETTLE_CYC   = CYC_PER_US * SETTLE_NS / 1000;
  localparam int unsigned INTERVAL_CYC = CYC_PER_US * INTERVAL_US;
  localparam int unsigned COL_W        = $clog2(NCOL);

  logic             tick;
  logic             walk_done;
  logic             walk_active;
  logic             sample_en;
  logic [COL_W-1:0] sample_col;
  logic [NCOL-1:0]  col_sel;
  logic [NROW-1:0]  rows_s;

  kbscan_tick #(.LIMIT(INTERVAL_CYC)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .tick   (tick)
  );

  kbscan_sync #(.WIDTH(NROW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rows_in),
    .dout  (rows_s)
  );

  kbscan_seq #(.NCOL(NCOL), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .tick        (tick),
    .walk_done   (walk_done),
    .col_sel     (col_sel),
    .charge      (charge),
    .sample_en   (sample_en),
    .sample_col  (sample_col),
    .walk_active (walk_active)
  );

  kbscan_delta #(.NCOL(NCOL), .NROW(NROW)) u_delta (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (sample_en),
    .sample_col  (sample_col),
    .rows        (rows_s),
    .walk_active (walk_active),
    .ev_ready    (ev_ready),
    .ev_valid    (ev_valid),
    .ev_index    (ev_index),
    .ev_pressed  (ev_pressed),
    .walk_done   (walk_done)
  );

  assign col_lo = col_sel[7:0];
  assign col_hi = col_sel[NCOL-1:8];

  initial begin
    a_settle_vs_sync_r3: assert (SETTLE_CYC > SYNC_STAGES + 1);
  end
endmodule

// File: tb/tb_kbscan_top.sv
module tb_kbscan_top;
  localparam int SET   = 20;
  localparam int LIM   = 1000;
  localparam int NC    = 12;
  localparam int NR    = 7;
  localparam int NK    = NC * NR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       ev_ready = 1'b1;
  logic [7:0] col_lo;
  logic [3:0] col_hi;
  logic       charge;
  logic [6:0] rows_in;
  logic       ev_valid;
  logic [6:0] ev_index;
  logic       ev_pressed;

  logic [NK-1:0] keys = '0;
  logic [NK-1:0] model_prev = '0;
  logic [NC-1:0] cols_w;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbscan_top #(.CLK_HZ(125_000_000), .SETTLE_NS(160), .INTERVAL_US(8)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .col_lo(col_lo), .col_hi(col_hi), .charge(charge),
    .rows_in(rows_in), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_index(ev_index), .ev_pressed(ev_pressed)
  );

  assign cols_w = {col_hi, col_lo};

  // Key matrix model: a pressed key connects its column drive to its row
  always_comb begin
    rows_in = '0;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        if (cols_w[c] && keys[r + c * NR]) rows_in[r] = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Pin protocol monitor
  int ch_len = 0, sel_len = 0, pulse_no = 0, exp_col = 0;
  int starts = 0, scans_done = 0, last_start = 0, prev_start = 0;
  int viol_onehot = 0, viol_overlap = 0;
  logic p_charge = 0;
  logic [NC-1:0] p_cols = '0;
  int n_ev = 0;
  int ev_i [0:127];
  int ev_p [0:127];

  always @(negedge clk) begin
    if (rst_n) begin
      if (cols_w != 0 && (cols_w & (cols_w - 1)) != 0) viol_onehot++;
      if (charge && cols_w != 0) viol_overlap++;
      if (charge && !p_charge && pulse_no == 0) begin
        prev_start = last_start;
        last_start = cyc;
        starts++;
      end
      if (p_cols != 0 && cols_w != p_cols) begin
        chk(sel_len == SET, "R3 select width", sel_len, SET);
        chk(charge == 1'b1, "R3 precharge after select", charge, 1);
        sel_len = 0;
        exp_col = (exp_col + 1) % NC;
      end
      if (!charge && p_charge) begin
        chk(ch_len == SET, "R3 charge width", ch_len, SET);
        ch_len = 0;
        pulse_no++;
        if (pulse_no == NC + 1) begin
          chk(cols_w == 0 && exp_col == 0, "R4 released after final charge", cols_w, 0);
          pulse_no = 0;
          scans_done++;
        end else begin
          chk(cols_w == (12'd1 << exp_col), "R2 one-hot column order", cols_w, 1 << exp_col);
        end
      end
      if (charge) ch_len++;
      if (cols_w != 0) sel_len++;
      p_charge = charge;
      p_cols = cols_w;
      if (ev_valid && ev_ready) begin
        if (n_ev < 128) begin
          ev_i[n_ev] = ev_index;
          ev_p[n_ev] = ev_pressed;
        end
        n_ev++;
      end
    end
  end

  task automatic run_scan();
    int n = scans_done;
    while (scans_done == n) @(negedge clk);
    repeat (150) @(negedge clk);
  endtask

  task automatic expect_events(input string tag);
    int k = 0;
    for (int i = 0; i < NK; i++) begin
      if (keys[i] != model_prev[i]) begin
        if (k < n_ev) begin
          chk(ev_i[k] == i, {tag, " event index"}, ev_i[k], i);
          chk(ev_p[k] == int'(keys[i]), {tag, " event flag"}, ev_p[k], keys[i]);
        end
        k++;
      end
    end
    chk(n_ev == k, {tag, " event count"}, n_ev, k);
    model_prev = keys;
    n_ev = 0;
  endtask

  task automatic t_reset();
    chk(cols_w == 0, "R1 columns after reset", cols_w, 0);
    chk(charge == 0, "R1 charge after reset", charge, 0);
    chk(ev_valid == 0, "R1 valid after reset", ev_valid, 0);
  endtask

  task automatic t_idle_scan();
    run_scan();
    expect_events("R6 empty matrix");
  endtask

  task automatic t_interval();
    run_scan();
    run_scan();
    chk(last_start - prev_start == LIM, "R8 interval", last_start - prev_start, LIM);
    expect_events("R8 no change");
  endtask

  task automatic t_single();
    keys[3 + 5 * NR] = 1'b1;  // R5: row 3, column 5 -> index 38
    run_scan();
    chk(n_ev == 1 && ev_i[0] == 38, "R5 index row+7*col", ev_i[0], 38);
    expect_events("R1 first press reported");
    run_scan();
    expect_events("R6 unchanged gives none");
    keys[38] = 1'b0;
    run_scan();
    expect_events("R6 release");
  endtask

  task automatic t_corners();
    keys[0] = 1'b1;   // row 0 col 0
    keys[55] = 1'b1;  // row 6 col 7, last col_lo bit
    keys[56] = 1'b1;  // row 0 col 8, col_hi[0]
    keys[83] = 1'b1;  // row 6 col 11
    run_scan();
    expect_events("R2 R5 corner keys ascending");
  endtask

  task automatic t_between();
    keys[20] = 1'b1;
    repeat (50) @(negedge clk);
    keys[20] = 1'b0;
    run_scan();
    expect_events("R10 between scans");
  endtask

  task automatic t_backpressure();
    int n = scans_done;
    int guard = 0;
    ev_ready = 1'b0;
    keys[0] = 1'b0;
    keys[83] = 1'b0;
    keys[10] = 1'b1;
    while (scans_done == n) @(negedge clk);
    while (!ev_valid && guard < 200) begin @(negedge clk); guard++; end
    chk(ev_valid && ev_index == 0 && ev_pressed == 0, "R7 first held event", ev_index, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!(ev_valid && ev_index == 0 && ev_pressed == 0)) begin
        chk(0, "R7 held stable", ev_index, 0);
        break;
      end
    end
    ev_ready = 1'b1;
    repeat (150) @(negedge clk);
    expect_events("R7 after release of back-pressure");
  endtask

  task automatic t_enable();
    int s0;
    int c0;
    enable = 1'b0;
    keys[70] = 1'b1;
    s0 = starts;
    repeat (2500) @(negedge clk);
    chk(starts == s0, "R9 no scan while disabled", starts - s0, 0);
    chk(n_ev == 0 && ev_valid == 0, "R9 no event while disabled", n_ev, 0);
    enable = 1'b1;
    c0 = cyc;
    while (starts == s0) @(negedge clk);
    chk(last_start - c0 == LIM, "R8 first scan after enable", last_start - c0, LIM);
    run_scan();
    expect_events("R9 resumed");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    t_idle_scan();
    t_interval();
    t_single();
    t_corners();
    t_between();
    t_backpressure();
    t_enable();
    chk(viol_onehot == 0, "R2 never two columns", viol_onehot, 0);
    chk(viol_overlap == 0, "R3 charge only with columns released", viol_overlap, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule